// File: doc/BRIEF.md
# Scan-Mode Clock and Reset Controller

This block puts the clocks, asynchronous resets and asynchronous sets that a logic region creates for itself under the control of the test pins while scan test runs. A clock selector swaps the region's generated clock for the test clock whenever scan mode is on. A bank of steering cells handles every internally generated reset/set pair. One signal of each pair is turned off for the whole of scan mode. The other is taken from the chip's external hard reset while the asynchronous scan-enable control is high.

The selected clock also feeds a row of latch-based clock gates. Each gate ORs its functional enable with the shared gated-clock scan-enable. A latch that is transparent only while the clock is low holds the result, and the clock is ANDed with the latch output. An enable that moves while the clock is high therefore cannot cut or stretch a pulse. Driving the scan-enable high makes every gated clock run freely for shifting.

All resets and sets are active low. The parameter `DROP_SIG` chooses which signal of each pair is turned off in scan mode. Its default turns off the set and steers the reset.

Top module: `scan_clk_rst_ctl`

## Requirements
- R1: `clk_out` follows `tst_clk` while `scan_mode` is 1 and follows `gen_clk` while `scan_mode` is 0.
- R2: The steered signal of each pair follows `ext_rst_n` while `async_se` is 1 and follows its internal source while `async_se` is 0. With the default `DROP_SIG` the steered signal is the reset, so `rst_n_out[i]` follows either `ext_rst_n` or `int_rst_n[i]`.
- R3: While `scan_mode` is 1, the dropped signal of every pair is held at 1 (inactive) whatever its internal source and `async_se` do. With the default `DROP_SIG` the dropped signal is the set, so every bit of `set_n_out` is held at 1.
- R4: While `scan_mode` is 0, the dropped signal of each pair follows its internal source, and `async_se` has no effect on it.
- R5: A change of a gate's enable (`func_en[i]` OR `gclk_se`) during the high phase of `clk_out` leaves `gclk_out[i]` unchanged until `clk_out` falls. No extra rising edge and no shortened pulse appear on `gclk_out[i]`.
- R6: `gclk_out[i]` is `clk_out` ANDed with the enable latched during the preceding low phase. With `gclk_se` at 1, every gate gives one pulse per `clk_out` pulse even when its functional enable is 0.
- R7: A gate whose enable stays 0 through a low phase keeps `gclk_out[i]` at 0 through the following high phase. Each gate is controlled only by its own `func_en` bit and by `gclk_se`.
- R8: The gates are clocked from the selected clock, so in scan mode with `gclk_se` at 1 every `gclk_out` bit follows `tst_clk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| gen_clk | input | 1 | Internally generated (divided) functional clock |
| tst_clk | input | 1 | Test clock from a chip pin |
| scan_mode | input | 1 | Scan mode: selects the test clock and turns off one signal of each pair |
| async_se | input | 1 | Asynchronous scan control: steers the hard reset onto the kept signals |
| gclk_se | input | 1 | Gated-clock scan-enable that forces all gates open |
| ext_rst_n | input | 1 | External hard reset, active low |
| int_rst_n | input | N_PAIR | Internally generated resets, active low |
| int_set_n | input | N_PAIR | Internally generated sets, active low |
| func_en | input | N_GATE | Functional enables, one per clock gate |
| clk_out | output | 1 | Controlled clock |
| rst_n_out | output | N_PAIR | Controlled resets, active low |
| set_n_out | output | N_PAIR | Controlled sets, active low |
| gclk_out | output | N_GATE | Gated clocks |

## Verification
The assertions check on every edge of the test clock that, in scan mode, the controlled clock is high during the test clock's high phase. On the same edges they check that, while the hard reset is inactive, scan mode keeps every dropped signal inactive and the asynchronous control keeps every steered signal inactive. On every falling edge of the controlled clock they check that the gated clocks were high throughout the preceding high phase whenever the scan-enable override held. Only the directed scenarios can show that an enable toggled in mid-high-phase neither clips nor adds a pulse, and that the hard reset actually reaches the steered outputs. The same applies to the controlled outputs returning to their internal sources outside scan mode, and to gates with different enables staying independent.

// File: rtl/scan_ctl_pkg.sv
package scan_ctl_pkg;

    // Which signal of an internally generated reset/set pair is turned off
    // for the whole of scan mode; the other one is steered to the hard reset.
    typedef enum logic {
        DROP_SET   = 1'b0,
        DROP_RESET = 1'b1
    } drop_sel_e;

    // Inactive level of the active-low asynchronous controls.
    localparam logic ASYNC_IDLE = 1'b1;

endpackage

// File: rtl/scan_clk_sel.sv
module scan_clk_sel (
    input  logic gen_clk,
    input  logic tst_clk,
    input  logic scan_mode,
    output logic clk_out
);

    // Plain select: glitch-free switching is not attempted, since scan mode
    // is static while any clock is running.
    always_comb begin
        if (scan_mode) begin
            clk_out = tst_clk;
        end else begin
            clk_out = gen_clk;
        end
    end

endmodule

// File: rtl/scan_async_steer.sv
module scan_async_steer
    import scan_ctl_pkg::*;
#(
    parameter drop_sel_e DROP_SIG = DROP_SET,
    parameter int        N_PAIR   = 2
) (
    input  logic              scan_mode,
    input  logic              async_se,
    input  logic              ext_rst_n,
    input  logic [N_PAIR-1:0] int_rst_n,
    input  logic [N_PAIR-1:0] int_set_n,
    output logic [N_PAIR-1:0] rst_n_out,
    output logic [N_PAIR-1:0] set_n_out
);

    localparam bit KEEP_RST = (DROP_SIG == DROP_SET);

    logic [N_PAIR-1:0] keep_src;
    logic [N_PAIR-1:0] drop_src;
    logic [N_PAIR-1:0] keep_res;
    logic [N_PAIR-1:0] drop_res;

    // Pick which internal source is kept and which is dropped.
    generate
        if (KEEP_RST) begin : g_keep_rst
            assign keep_src  = int_rst_n;
            assign drop_src  = int_set_n;
            assign rst_n_out = keep_res;
            assign set_n_out = drop_res;
        end else begin : g_keep_set
            assign keep_src  = int_set_n;
            assign drop_src  = int_rst_n;
            assign set_n_out = keep_res;
            assign rst_n_out = drop_res;
        end
    endgenerate

    // One steering cell per pair.
    generate
        for (genvar i = 0; i < N_PAIR; i++) begin : g_pair
            always_comb begin
                keep_res[i] = async_se  ? ext_rst_n  : keep_src[i];
                drop_res[i] = scan_mode ? ASYNC_IDLE : drop_src[i];
            end
        end
    endgenerate

endmodule

// File: rtl/scan_clk_gate.sv
module scan_clk_gate (
    input  logic clk,
    input  logic func_en,
    input  logic test_en,
    output logic gclk
);

    typedef struct packed {
        logic en;
    } gate_st_t;

    gate_st_t st_d;
    gate_st_t st_q;

    always_comb begin
        st_d    = st_q;
        st_d.en = func_en | test_en;
    end

    // Transparent while the clock is low, so the enable is frozen for
    // the whole high phase.
    always_latch begin
        if (!clk) begin
            st_q = st_d;
        end
    end

    assign gclk = clk & st_q.en;

endmodule

// File: rtl/scan_clk_rst_ctl.sv
module scan_clk_rst_ctl
    import scan_ctl_pkg::*;
#(
    parameter drop_sel_e DROP_SIG = DROP_SET,
    parameter int        N_PAIR   = 2,
    parameter int        N_GATE   = 2
) (
    input  logic              gen_clk,
    input  logic              tst_clk,
    input  logic              scan_mode,
    input  logic              async_se,
    input  logic              gclk_se,
    input  logic              ext_rst_n,
    input  logic [N_PAIR-1:0] int_rst_n,
    input  logic [N_PAIR-1:0] int_set_n,
    input  logic [N_GATE-1:0] func_en,
    output logic              clk_out,
    output logic [N_PAIR-1:0] rst_n_out,
    output logic [N_PAIR-1:0] set_n_out,
    output logic [N_GATE-1:0] gclk_out
);

    logic clk_sel;

    scan_clk_sel u_sel (
        .gen_clk   (gen_clk),
        .tst_clk   (tst_clk),
        .scan_mode (scan_mode),
        .clk_out   (clk_sel)
    );

    assign clk_out = clk_sel;

    scan_async_steer #(
        .DROP_SIG (DROP_SIG),
        .N_PAIR   (N_PAIR)
    ) u_steer (
        .scan_mode (scan_mode),
        .async_se  (async_se),
        .ext_rst_n (ext_rst_n),
        .int_rst_n (int_rst_n),
        .int_set_n (int_set_n),
        .rst_n_out (rst_n_out),
        .set_n_out (set_n_out)
    );

    generate
        for (genvar g = 0; g < N_GATE; g++) begin : g_gate
            scan_clk_gate u_gate (
                .clk     (clk_sel),
                .func_en (func_en[g]),
                .test_en (gclk_se),
                .gclk    (gclk_out[g])
            );
        end
    endgenerate

endmodule

// File: rtl/scan_clk_rst_chk.sv
module scan_clk_rst_chk
    import scan_ctl_pkg::*;
#(
    parameter drop_sel_e DROP_SIG = DROP_SET,
    parameter int        N_PAIR   = 2,
    parameter int        N_GATE   = 2
) (
    input logic              tst_clk,
    input logic              scan_mode,
    input logic              async_se,
    input logic              gclk_se,
    input logic              ext_rst_n,
    input logic              clk_out,
    input logic [N_PAIR-1:0] rst_n_out,
    input logic [N_PAIR-1:0] set_n_out,
    input logic [N_GATE-1:0] gclk_out
);

    localparam bit KEEP_RST = (DROP_SIG == DROP_SET);

    logic [N_PAIR-1:0] kept;
    logic [N_PAIR-1:0] dropped;

    assign kept    = KEEP_RST ? rst_n_out : set_n_out;
    assign dropped = KEEP_RST ? set_n_out : rst_n_out;

    // Scan mode held across a test-clock cycle: the high phase reaches clk_out.
    p_clk_scan_r1: assert property (@(negedge tst_clk) disable iff (!ext_rst_n)
        (scan_mode && $past(scan_mode)) |-> clk_out)
        else $error("R1 clk_out low during test clock high phase");

    // Hard reset idle and asynchronous control on: every kept signal idle.
    p_steer_r2: assert property (@(posedge tst_clk) disable iff (!ext_rst_n)
        async_se |-> (&kept))
        else $error("R2 steered signal not taken from hard reset");

    // Scan mode: every dropped signal idle.
    p_drop_r3: assert property (@(posedge tst_clk) disable iff (!ext_rst_n)
        scan_mode |-> (&dropped))
        else $error("R3 dropped signal active in scan mode");

    // Override held: each gated clock was high for the whole high phase.
    p_free_run_r6: assert property (@(negedge clk_out) disable iff (!ext_rst_n)
        (gclk_se && $past(gclk_se)) |-> (&gclk_out))
        else $error("R6 gated clock missing with override high");

endmodule

bind scan_clk_rst_ctl scan_clk_rst_chk #(
    .DROP_SIG (DROP_SIG),
    .N_PAIR   (N_PAIR),
    .N_GATE   (N_GATE)
) u_chk (
    .tst_clk   (tst_clk),
    .scan_mode (scan_mode),
    .async_se  (async_se),
    .gclk_se   (gclk_se),
    .ext_rst_n (ext_rst_n),
    .clk_out   (clk_out),
    .rst_n_out (rst_n_out),
    .set_n_out (set_n_out),
    .gclk_out  (gclk_out)
);

// File: tb/tb_scan_clk_rst_ctl.sv
module tb_scan_clk_rst_ctl;
    import scan_ctl_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = CLK_PERIOD / 2;
    localparam int NP         = 2;
    localparam int NG         = 2;

    logic          gen_clk;
    logic          tst_clk;
    logic          scan_mode;
    logic          async_se;
    logic          gclk_se;
    logic          ext_rst_n;
    logic [NP-1:0] int_rst_n;
    logic [NP-1:0] int_set_n;
    logic [NG-1:0] func_en;
    logic          clk_out;
    logic [NP-1:0] rst_n_out;
    logic [NP-1:0] set_n_out;
    logic [NG-1:0] gclk_out;

    int n_chk;
    int n_bad;
    int edges0;
    int edges1;

    scan_clk_rst_ctl #(
        .DROP_SIG (DROP_SET),
        .N_PAIR   (NP),
        .N_GATE   (NG)
    ) dut (
        .gen_clk   (gen_clk),
        .tst_clk   (tst_clk),
        .scan_mode (scan_mode),
        .async_se  (async_se),
        .gclk_se   (gclk_se),
        .ext_rst_n (ext_rst_n),
        .int_rst_n (int_rst_n),
        .int_set_n (int_set_n),
        .func_en   (func_en),
        .clk_out   (clk_out),
        .rst_n_out (rst_n_out),
        .set_n_out (set_n_out),
        .gclk_out  (gclk_out)
    );

    initial tst_clk = 1'b0;
    always #(HALF) tst_clk = ~tst_clk;

    always @(posedge gclk_out[0]) edges0 = edges0 + 1;
    always @(posedge gclk_out[1]) edges1 = edges1 + 1;

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_gen();
        gen_clk = 1'b1;
        #(HALF);
        gen_clk = 1'b0;
        #(HALF);
    endtask

    task automatic t_reset();
        scan_mode = 1'b0; async_se = 1'b1; gclk_se = 1'b0;
        ext_rst_n = 1'b0; int_rst_n = '1; int_set_n = '1;
        func_en = '0; gen_clk = 1'b0;
        #(3 * CLK_PERIOD + 2);
        check(rst_n_out == 2'b00, "R2 hard reset reaches resets", rst_n_out, 0);
        check(gclk_out == 2'b00, "R7 gates closed at start", gclk_out, 0);
        ext_rst_n = 1'b1;
        #2;
        check(rst_n_out == 2'b11, "R2 hard reset released", rst_n_out, 3);
    endtask

    task automatic t_clk_mux();
        scan_mode = 1'b0;
        gen_clk = 1'b1; #2;
        check(clk_out == 1'b1, "R1 generated clock high", clk_out, 1);
        gen_clk = 1'b0; #2;
        check(clk_out == 1'b0, "R1 generated clock low", clk_out, 0);
        scan_mode = 1'b1;
        @(posedge tst_clk); #2;
        check(clk_out == 1'b1, "R1 test clock high", clk_out, 1);
        @(negedge tst_clk); #2;
        check(clk_out == 1'b0, "R1 test clock low", clk_out, 0);
        gen_clk = 1'b1; #1;
        check(clk_out == 1'b0, "R1 generated clock ignored in scan", clk_out, 0);
        gen_clk = 1'b0;
        scan_mode = 1'b0;
        @(posedge tst_clk); #2;
        check(clk_out == 1'b0, "R1 test clock ignored outside scan", clk_out, 0);
    endtask

    task automatic t_steer();
        scan_mode = 1'b0; async_se = 1'b0; ext_rst_n = 1'b1;
        int_rst_n = 2'b10; int_set_n = 2'b01; #2;
        check(rst_n_out == 2'b10, "R2 reset from internal source", rst_n_out, 2);
        check(set_n_out == 2'b01, "R4 set follows internal outside scan", set_n_out, 1);
        async_se = 1'b1; #2;
        check(rst_n_out == 2'b11, "R2 internal reset blocked", rst_n_out, 3);
        check(set_n_out == 2'b01, "R4 async control leaves set alone", set_n_out, 1);
        ext_rst_n = 1'b0; #2;
        check(rst_n_out == 2'b00, "R2 hard reset steered", rst_n_out, 0);
        ext_rst_n = 1'b1;
        scan_mode = 1'b1; int_set_n = 2'b00; #2;
        check(set_n_out == 2'b11, "R3 set dropped in scan", set_n_out, 3);
        async_se = 1'b0; #2;
        check(set_n_out == 2'b11, "R3 set dropped without async control", set_n_out, 3);
        check(rst_n_out == 2'b10, "R2 reset internal with async off", rst_n_out, 2);
        scan_mode = 1'b0; #2;
        check(set_n_out == 2'b00, "R4 set restored after scan", set_n_out, 0);
        int_rst_n = '1; int_set_n = '1;
    endtask

    task automatic t_glitch();
        scan_mode = 1'b0; gclk_se = 1'b0; func_en = '0; gen_clk = 1'b0;
        #(HALF);
        edges0 = 0; edges1 = 0;
        gen_clk = 1'b1; #3;
        func_en[0] = 1'b1; #2;
        check(gclk_out[0] == 1'b0, "R5 late enable held off in high phase", gclk_out[0], 0);
        gen_clk = 1'b0; #(HALF);
        check(gclk_out[0] == 1'b0, "R5 low phase stays low", gclk_out[0], 0);
        gen_clk = 1'b1; #2;
        check(gclk_out[0] == 1'b1, "R6 latched enable passes pulse", gclk_out[0], 1);
        check(gclk_out[1] == 1'b0, "R7 other gate stays closed", gclk_out[1], 0);
        func_en[0] = 1'b0; #2;
        check(gclk_out[0] == 1'b1, "R5 pulse not clipped", gclk_out[0], 1);
        gen_clk = 1'b0; #(HALF);
        gen_clk = 1'b1; #3;
        check(gclk_out[0] == 1'b0, "R7 disabled gate blocks pulse", gclk_out[0], 0);
        gen_clk = 1'b0; #(HALF);
        check(edges0 == 1, "R5 exactly one gated edge", edges0, 1);
        check(edges1 == 0, "R7 no edge on closed gate", edges1, 0);
    endtask

    task automatic t_free_run();
        scan_mode = 1'b0; func_en = '0; gen_clk = 1'b0;
        gclk_se = 1'b1;
        #(HALF);
        edges0 = 0; edges1 = 0;
        for (int k = 0; k < 3; k++) pulse_gen();
        check(edges0 == 3, "R6 override pulses gate 0", edges0, 3);
        check(edges1 == 3, "R6 override pulses gate 1", edges1, 3);
        scan_mode = 1'b1;
        @(posedge tst_clk); #2;
        check(gclk_out == 2'b11, "R8 gates follow test clock high", gclk_out, 3);
        @(negedge tst_clk); #2;
        check(gclk_out == 2'b00, "R8 gates follow test clock low", gclk_out, 0);
        gclk_se = 1'b0;
        @(posedge tst_clk); @(posedge tst_clk); #2;
        check(gclk_out == 2'b00, "R7 override removed closes gates", gclk_out, 0);
        scan_mode = 1'b0;
    endtask

    initial begin
        n_chk = 0; n_bad = 0; edges0 = 0; edges1 = 0;
        t_reset();
        t_clk_mux();
        t_steer();
        t_glitch();
        t_free_run();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk = n_chk + 1;
        n_bad = n_bad + 1;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule